// File: doc/BRIEF.md
# Peak Magnitude Tracker with Source Tag

This block watches signed waveform samples from two current inputs (A and B) and one voltage input. It holds the largest scaled magnitude seen since the last read. Each sample's magnitude is taken first, clipped so that the most negative code cannot overflow, and then shifted right by five bits. The voltage channel has its own peak register. Both current channels share one peak register. Beside the shared value sits a small tag that tells which current input produced the stored maximum.

A two-bit monitor select decides which current inputs take part in the shared peak. A host reads a peak through a simple read port, and the read clears that register. Each read therefore returns the peak of the interval since the previous read of the same register.

Top module: `peak_tracker_top`

## Requirements
- R1: After reset both peak values and the tag are zero, so a read of either register returns 0.
- R2: The stored quantity for a sample is its absolute value shifted right by 5 bits (floor of magnitude/32), so +3200 and -3231 both give 100.
- R3: The most negative input code (-2^23 for 24-bit samples) is clipped to 2^23-1 before shifting, giving 262143. No stored value ever exceeds 262143.
- R4: A monitored channel replaces the stored current peak only when its scaled magnitude is strictly greater. The tag is then rewritten to mark only the channels holding the new value. An equal value leaves value and tag unchanged. The tag is nonzero exactly when the value is nonzero.
- R5: Monitor select bit 0 enables current A and bit 1 enables current B. Samples on a disabled input have no effect on the current peak.
- R6: When both enabled channels exceed the stored peak in one cycle, the larger one is stored. Tag bit 0 marks A and tag bit 1 marks B. On an equal pair both bits are set. Tag bit 2 is always zero.
- R7: The voltage peak is tracked in its own register, always monitored, and is independent of the current peak and the monitor select.
- R8: A read with rd_addr=0 selects the current register and rd_addr=1 selects the voltage register. rd_data shows the word from the cycle after rd_en. The current word is {5'b0, tag[2:0], value[23:0]}. The voltage word is {8'b0, value[23:0]}.
- R9: A read clears only the addressed register (value and tag) after returning its contents. A sample arriving in the read cycle is applied on top of the cleared state.
- R10: Inputs are sampled only when smp_valid is high. Otherwise no peak changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe for all three inputs |
| cur_a | input | 24 | Signed sample, current A |
| cur_b | input | 24 | Signed sample, current B |
| volt | input | 24 | Signed sample, voltage |
| mon_sel | input | 2 | Current monitor enables (bit0 A, bit1 B) |
| rd_en | input | 1 | Read strobe, clears the addressed peak |
| rd_addr | input | 1 | 0 = current peak, 1 = voltage peak |
| rd_data | output | 32 | Registered read word |

## Verification
Directed cases cover the sign handling by pairing positive and negative codes with the same scaled result. They also cover the clipped minimum code, a tie against the stored peak that must not rewrite the tag, and an equal pair between A and B that must set both tag bits. Further directed cases show that a disabled channel carrying a large sample is ignored, that a read coinciding with a sample leaves the fresh sample rather than zero, and that a voltage read leaves the current peak intact. Random traffic mixes small, full-range and minimum codes with random select, strobe and reads. The random reads tell an off-by-one in the shift or a wrong winner choice apart from a missed clear.

// File: rtl/peak_pkg.sv
package peak_pkg;
  localparam int WORD_W = 32;

  typedef enum logic {
    RD_CUR  = 1'b0,
    RD_VOLT = 1'b1
  } peak_rd_e;
endpackage

// File: rtl/peak_mag.sv
module peak_mag #(
  parameter int SMP_W = 24,
  parameter int SHIFT = 5,
  parameter int VAL_W = 24
) (
  input  logic signed [SMP_W-1:0] smp,
  output logic        [VAL_W-1:0] mag
);
  localparam int ABS_W = SMP_W - 1;

  // Absolute value with the most negative code clipped to the largest positive.
  function automatic logic [ABS_W-1:0] sat_abs(input logic signed [SMP_W-1:0] x);
    logic signed [SMP_W-1:0] neg;
    if (x[SMP_W-1] == 1'b0) begin
      return x[ABS_W-1:0];
    end
    if (x[ABS_W-1:0] == '0) begin
      return '1;
    end
    neg = -x;
    return neg[ABS_W-1:0];
  endfunction

  function automatic logic [ABS_W-1:0] scale(input logic [ABS_W-1:0] a);
    return a >> SHIFT;
  endfunction

  logic [ABS_W-1:0] abs_v;
  logic [ABS_W-1:0] scl_v;

  assign abs_v = sat_abs(smp);
  assign scl_v = scale(abs_v);
  assign mag   = VAL_W'(scl_v);
endmodule

// File: rtl/peak_hold.sv
module peak_hold #(
  parameter int NCH   = 2,
  parameter int VAL_W = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            cand_vld,
  input  logic [NCH-1:0][VAL_W-1:0] cand_mag,
  input  logic                      clr,
  output logic [VAL_W-1:0]          val_q,
  output logic [NCH-1:0]            tag_q,
  output logic                      upd
);
  logic [VAL_W-1:0] base;
  logic [VAL_W-1:0] best;
  logic [NCH-1:0]   nxt_tag;

  // Largest magnitude among the enabled candidates this cycle.
  always_comb begin
    best = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cand_vld[i] && (cand_mag[i] > best)) begin
        best = cand_mag[i];
      end
    end
  end

  // A clear in this cycle makes the new sample compete against zero.
  assign base = clr ? '0 : val_q;
  assign upd  = best > base;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      nxt_tag[i] = upd && cand_vld[i] && (cand_mag[i] == best);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      tag_q <= '0;
    end else if (upd) begin
      val_q <= best;
      tag_q <= nxt_tag;
    end else if (clr) begin
      val_q <= '0;
      tag_q <= '0;
    end
  end
endmodule

// File: rtl/peak_tracker_top.sv
module peak_tracker_top #(
  parameter int SMP_W = 24,
  parameter int SHIFT = 5,
  parameter int VAL_W = 24,
  parameter int TAG_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        smp_valid,
  input  logic signed [SMP_W-1:0]     cur_a,
  input  logic signed [SMP_W-1:0]     cur_b,
  input  logic signed [SMP_W-1:0]     volt,
  input  logic [1:0]                  mon_sel,
  input  logic                        rd_en,
  input  logic                        rd_addr,
  output logic [peak_pkg::WORD_W-1:0] rd_data
);
  import peak_pkg::*;

  localparam int NCUR = 2;
  localparam int NALL = NCUR + 1;

  logic [NALL-1:0][SMP_W-1:0] smp_all;
  logic [NALL-1:0][VAL_W-1:0] mag_all;

  assign smp_all = {volt, cur_b, cur_a};

  for (genvar g = 0; g < NALL; g++) begin : g_mag
    peak_mag #(.SMP_W(SMP_W), .SHIFT(SHIFT), .VAL_W(VAL_W)) u_mag (
      .smp (smp_all[g]),
      .mag (mag_all[g])
    );
  end

  // Named events used by the checker.
  logic             rd_cur;
  logic             rd_volt;
  logic             cur_upd;
  logic             volt_upd;
  logic [NCUR-1:0]  cur_vld;
  logic [VAL_W-1:0] cur_val;
  logic [NCUR-1:0]  cur_tag;
  logic [VAL_W-1:0] volt_val;
  logic [0:0]       volt_tag;

  assign rd_cur  = rd_en && (peak_rd_e'(rd_addr) == RD_CUR);
  assign rd_volt = rd_en && (peak_rd_e'(rd_addr) == RD_VOLT);
  assign cur_vld = {NCUR{smp_valid}} & mon_sel;

  peak_hold #(.NCH(NCUR), .VAL_W(VAL_W)) u_cur (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand_vld (cur_vld),
    .cand_mag (mag_all[NCUR-1:0]),
    .clr      (rd_cur),
    .val_q    (cur_val),
    .tag_q    (cur_tag),
    .upd      (cur_upd)
  );

  peak_hold #(.NCH(1), .VAL_W(VAL_W)) u_volt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand_vld (smp_valid),
    .cand_mag (mag_all[NALL-1]),
    .clr      (rd_volt),
    .val_q    (volt_val),
    .tag_q    (volt_tag),
    .upd      (volt_upd)
  );

  logic [TAG_W-1:0]  cur_tag_w;
  logic [WORD_W-1:0] cur_word;
  logic [WORD_W-1:0] volt_word;

  assign cur_tag_w = TAG_W'(cur_tag);
  assign cur_word  = WORD_W'({cur_tag_w, cur_val});
  assign volt_word = WORD_W'(volt_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_volt ? volt_word : cur_word;
    end
  end
endmodule

// File: rtl/peak_tracker_chk.sv
module peak_tracker_chk #(
  parameter int SMP_W = 24,
  parameter int SHIFT = 5,
  parameter int VAL_W = 24,
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic [1:0]       mon_sel,
  input logic             rd_cur,
  input logic             rd_volt,
  input logic             cur_upd,
  input logic [VAL_W-1:0] cur_val,
  input logic [1:0]       cur_tag,
  input logic [VAL_W-1:0] volt_val,
  input logic [31:0]      rd_data
);
  localparam logic [VAL_W-1:0] MAXV = VAL_W'(((64'd1 << (SMP_W-1)) - 1) >> SHIFT);

  AST_RSV_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data >> (VAL_W + TAG_W)) == 0) else $error("reserved bits set"); // R8

  AST_PEAK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_val <= MAXV) && (volt_val <= MAXV)) else $error("peak above clip"); // R3

  AST_HOLD_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cur |=> cur_val >= $past(cur_val)) else $error("peak decreased"); // R4

  AST_TAG_MATCHES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_val != 0) == (cur_tag != 0)) else $error("tag/value mismatch"); // R4

  AST_UPD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cur_upd |=> cur_val != 0) else $error("update left zero"); // R4

  AST_UNSEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_sel == 2'b00 && !rd_cur) |=> ($stable(cur_val) && $stable(cur_tag)))
    else $error("unselected channel changed peak"); // R5

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !rd_cur && !rd_volt) |=> ($stable(cur_val) && $stable(volt_val)))
    else $error("peak changed without strobe"); // R10

  AST_VOLT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_volt && !smp_valid) |=> volt_val == 0) else $error("voltage not cleared"); // R9
endmodule

bind peak_tracker_top peak_tracker_chk #(
  .SMP_W(SMP_W), .SHIFT(SHIFT), .VAL_W(VAL_W), .TAG_W(TAG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .mon_sel   (mon_sel),
  .rd_cur    (rd_cur),
  .rd_volt   (rd_volt),
  .cur_upd   (cur_upd),
  .cur_val   (cur_val),
  .cur_tag   (cur_tag),
  .volt_val  (volt_val),
  .rd_data   (rd_data)
);

// File: tb/sim_peak_tracker_top.sv
`timescale 1ns/1ps
module sim_peak_tracker_top;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_valid = 1'b0;
  logic signed [23:0] cur_a = '0;
  logic signed [23:0] cur_b = '0;
  logic signed [23:0] volt = '0;
  logic [1:0]         mon_sel = 2'b11;
  logic               rd_en = 1'b0;
  logic               rd_addr = 1'b0;
  logic [31:0]        rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model state
  longint m_cur = 0;
  logic [1:0] m_tag = 2'b00;
  longint m_volt = 0;

  always #10 clk = ~clk;

  peak_tracker_top u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cur_a(cur_a),
    .cur_b(cur_b), .volt(volt), .mon_sel(mon_sel), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Magnitude by arithmetic on a wide integer: clip at 2^23-1, divide by 32.
  function automatic longint scaled(input logic signed [23:0] s);
    longint m;
    m = longint'(s);
    if (m < 0) m = -m;
    if (m > 64'd8388607) m = 8388607;
    return m / 32;
  endfunction

  function automatic logic [31:0] cur_word(input longint v, input logic [1:0] t);
    return {5'b0, 1'b0, t, v[23:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input string req, input bit v, input logic signed [23:0] a,
                     input logic signed [23:0] b, input logic signed [23:0] vv,
                     input logic [1:0] sel, input bit rd, input bit addr);
    logic [31:0] exp_rd;
    longint base, ma, mb, best, mv, vbase;
    bit ea, eb;
    @(negedge clk);
    smp_valid = v; cur_a = a; cur_b = b; volt = vv; mon_sel = sel;
    rd_en = rd; rd_addr = addr;
    exp_rd = addr ? {8'b0, m_volt[23:0]} : cur_word(m_cur, m_tag);
    // current register
    base = (rd && !addr) ? 0 : m_cur;
    ea = v && sel[0];
    eb = v && sel[1];
    ma = scaled(a);
    mb = scaled(b);
    best = 0;
    if (ea && ma > best) best = ma;
    if (eb && mb > best) best = mb;
    if (best > base) begin
      m_cur = best;
      m_tag = {eb && (mb == best), ea && (ma == best)};
    end else if (rd && !addr) begin
      m_cur = 0;
      m_tag = 2'b00;
    end
    // voltage register
    vbase = (rd && addr) ? 0 : m_volt;
    mv = v ? scaled(vv) : 0;
    if (mv > vbase) m_volt = mv;
    else if (rd && addr) m_volt = 0;
    @(posedge clk);
    #1;
    if (rd) check(req, rd_data, exp_rd);
    rd_en = 1'b0;
  endtask

  task automatic idle_read(input string req, input bit addr);
    cyc(req, 1'b0, 24'sd0, 24'sd0, 24'sd0, 2'b11, 1'b1, addr);
  endtask

  function automatic logic signed [23:0] rnd_smp();
    int k;
    k = $urandom_range(0, 9);
    if (k == 0) return 24'sh800000;
    if (k < 5) return 24'($signed($urandom_range(0, 20000)) - 10000);
    return 24'($urandom);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state on both registers
    idle_read("R1 current", 1'b0);
    idle_read("R1 voltage", 1'b1);

    // R2: positive and negative give same scaled result
    cyc("R2 pos", 1'b1, 24'sd3200, 24'sd0, 24'sd0, 2'b11, 1'b0, 1'b0);
    idle_read("R2 pos read", 1'b0);
    cyc("R2 neg", 1'b1, -24'sd3231, 24'sd0, 24'sd0, 2'b11, 1'b0, 1'b0);
    idle_read("R2 neg read", 1'b0);

    // R4: equal magnitude on B does not replace A's tag
    cyc("R4 set", 1'b1, 24'sd3200, 24'sd0, 24'sd0, 2'b11, 1'b0, 1'b0);
    cyc("R4 eq", 1'b1, 24'sd0, 24'sd3210, 24'sd0, 2'b11, 1'b0, 1'b0);
    idle_read("R4 equal keeps tag", 1'b0);

    // R3: most negative code is clipped
    cyc("R3 min", 1'b1, 24'sh800000, 24'sd0, -24'sd8388608, 2'b01, 1'b0, 1'b0);
    idle_read("R3 current", 1'b0);
    idle_read("R3 voltage", 1'b1);

    // R5: disabled B with large sample is ignored
    cyc("R5 a", 1'b1, 24'sd640, 24'sd4000000, 24'sd0, 2'b01, 1'b0, 1'b0);
    idle_read("R5 sel A only", 1'b0);
    cyc("R5 b", 1'b1, 24'sd4000000, -24'sd960, 24'sd0, 2'b10, 1'b0, 1'b0);
    idle_read("R5 sel B only", 1'b0);

    // R6: both exceed, B larger; then equal pair
    cyc("R6 b wins", 1'b1, 24'sd1000, -24'sd5000, 24'sd0, 2'b11, 1'b0, 1'b0);
    idle_read("R6 larger wins", 1'b0);
    cyc("R6 tie", 1'b1, -24'sd6400, 24'sd6400, 24'sd0, 2'b11, 1'b0, 1'b0);
    idle_read("R6 tie both bits", 1'b0);

    // R7: voltage independent; current read leaves voltage intact
    cyc("R7 v", 1'b1, 24'sd320, 24'sd0, -24'sd99999, 2'b00, 1'b0, 1'b0);
    idle_read("R7 current read", 1'b0);
    idle_read("R7 voltage kept", 1'b1);

    // R9: sample in the read cycle lands after the clear
    cyc("R9 load", 1'b1, 24'sd90000, 24'sd0, 24'sd70000, 2'b11, 1'b0, 1'b0);
    cyc("R9 rd+smp", 1'b1, 24'sd320, 24'sd0, 24'sd0, 2'b11, 1'b1, 1'b0);
    idle_read("R9 fresh sample kept", 1'b0);
    idle_read("R9 voltage untouched", 1'b1);

    // R10: no strobe, no change
    cyc("R10 nostrobe", 1'b0, 24'sd4000000, 24'sd4000000, 24'sd4000000, 2'b11, 1'b0, 1'b0);
    idle_read("R10 current", 1'b0);
    idle_read("R10 voltage", 1'b1);

    // R8/R4/R6 random traffic with random reads
    for (int i = 0; i < 3000; i++) begin
      cyc("random R4 R6 R8", ($urandom_range(0, 3) != 0), rnd_smp(), rnd_smp(), rnd_smp(),
          2'($urandom), ($urandom_range(0, 7) == 0), 1'($urandom));
    end
    idle_read("final R8 current", 1'b0);
    idle_read("final R8 voltage", 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule